// File: doc/BRIEF.md
# SPI Slave Serial Shifter with Hold

This block is the bit-level front end of a serial memory slave. It oversamples the serial clock, chip select, data input and hold pin in a faster system clock. Data is captured on each rising serial-clock edge and shifted out on each falling edge, most significant bit first. Bits are counted inside a chip-select frame. A command decoder behind the block receives every completed byte with a one-cycle strobe. It supplies the byte to send next on `tx_data_i`, and enables the output driver with `tx_en_i`.

Clock idle level low and clock idle level high are both accepted without configuration. A hold input pauses a frame in place. While paused, the output driver is released, input data and clock edges are ignored, and the bit position is kept. Entry into hold and exit from hold are only recognised while the serial clock is low. Raising chip select abandons the frame. The serial data output is presented as a value plus an output enable, so the pad ring can build the tri-state buffer.

Top module: `spi_hold_shifter`

## Requirements
- R1: After reset, `so_oe_o` and `rx_valid_o` are low and no byte has been reported.
- R2: Input bits are sampled on rising serial-clock edges, first bit as bit 7 (MSB). After every eighth sampled bit of a frame, `rx_data_o` carries the byte together with a single-cycle `rx_valid_o`. The count continues across bytes in the same frame.
- R3: `so_o` presents `tx_data_i` MSB first and changes only after falling serial-clock edges. A new `tx_data_i` value is captured at frame start and at the first falling edge after each completed byte.
- R4: Frames with the clock idling low and frames with the clock idling high both transfer bytes correctly in both directions.
- R5: `so_oe_o` is low whenever chip select (`csn_i`, active low) is high or `tx_en_i` is low.
- R6: Driving `hold_n_i` low while the serial clock is low puts the block on hold, and `so_oe_o` goes low.
- R7: During hold, clock edges and data changes alter neither the bit position nor the output data. After release, the byte completes with the bits sent before and after the pause.
- R8: A `hold_n_i` change made while the serial clock is high has no effect until the clock is next low.
- R9: Raising chip select discards a partly received byte, resets the bit count and clears hold.
- R10: A clock edge seen in the same cycle as a hold change is judged by the hold state before that cycle. An entering falling edge is honoured, and a falling edge that releases hold is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_n_i | input | 1 | Hold request, active low |
| tx_data_i | input | DATA_W | Next byte to shift out |
| tx_en_i | input | 1 | Allow driving the serial output |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Serial data out enable (low = high impedance) |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |

## Verification
Two events can land in the same sampled cycle: a hold change and a falling serial-clock edge. The bench provokes this by driving `sck_i` low and `hold_n_i` in the same system-clock cycle. It does so once for entry into hold and once for release. The verdict is read from the data the master captures after resuming. If the entering edge were dropped, or the releasing edge honoured, the output would be one bit out of step and the received byte would be wrong.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  // Qualified serial-clock events in the system clock domain
  typedef struct packed {
    logic active; // chip select asserted
    logic start;  // chip select just asserted
    logic rise;   // rising serial edge, not held
    logic fall;   // falling serial edge, not held
  } sck_evt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic csn_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held_d,
  output logic held_q
);
  // Hold may only change while the clock is low; chip select high clears it
  always_comb begin
    if (csn_s)       held_d = 1'b0;
    else if (!sck_s) held_d = !hold_n_s;
    else             held_d = held_q;
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= held_d;
  end

  assert_hold_frozen_sck_high_R8: assert property (@(posedge clk) disable iff (rst)
    (!csn_s && sck_s) |=> $stable(held_q));
  assert_hold_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (!csn_s && !sck_s && !hold_n_s) |=> held_q);
  assert_hold_cleared_by_cs_R9: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !held_q);
endmodule

// File: rtl/spi_edge_gen.sv
module spi_edge_gen
  import spi_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sck_s,
  input  logic     csn_s,
  input  logic     held_q,
  output sck_evt_t evt
);
  logic sck_prev_q;
  logic csn_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev_q <= 1'b0;
      csn_prev_q <= 1'b1;
    end else begin
      sck_prev_q <= sck_s;
      csn_prev_q <= csn_s;
    end
  end

  // Edges are gated by the hold state from before this cycle
  always_comb begin
    evt.active = !csn_s;
    evt.start  = !csn_s && csn_prev_q;
    evt.rise   = !csn_s && !held_q && sck_s && !sck_prev_q;
    evt.fall   = !csn_s && !held_q && !sck_s && sck_prev_q;
  end

  assert_no_edge_while_held_R7: assert property (@(posedge clk) disable iff (rst)
    held_q |-> !(evt.rise || evt.fall));
  assert_rise_is_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    evt.rise |=> !evt.rise);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  sck_evt_t          evt,
  input  logic              held_d,
  input  logic              held_q,
  input  logic              si_s,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_en_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] rx_sr_q;
  logic [DATA_W-1:0] tx_sr_q;
  logic [DATA_W-1:0] rx_next;

  assign rx_next = {rx_sr_q[DATA_W-2:0], si_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      rx_sr_q    <= '0;
      tx_sr_q    <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      so_oe_o    <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      so_oe_o    <= evt.active && !held_d && tx_en_i;
      if (!evt.active) begin
        cnt_q   <= '0;
        rx_sr_q <= '0;
      end else begin
        if (evt.start) tx_sr_q <= tx_data_i;
        if (evt.rise) begin
          rx_sr_q <= rx_next;
          if (cnt_q == CNT_LAST) begin
            cnt_q      <= '0;
            rx_data_o  <= rx_next;
            rx_valid_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        if (evt.fall) begin
          if (cnt_q == '0) tx_sr_q <= tx_data_i;
          else             tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_o = tx_sr_q[DATA_W-1];

  assert_count_frozen_in_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (held_q && evt.active) |=> $stable(cnt_q));
  assert_cs_high_idles_R5: assert property (@(posedge clk) disable iff (rst)
    !evt.active |=> (!so_oe_o && cnt_q == '0));
  assert_no_drive_in_hold_R6: assert property (@(posedge clk) disable iff (rst)
    so_oe_o |-> !held_q);
  assert_valid_single_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);
  assert_valid_at_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> (cnt_q == '0));
endmodule

// File: rtl/spi_hold_shifter.sv
module spi_hold_shifter
  import spi_hold_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic              si_i,
  input  logic              hold_n_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_en_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int PINS = 4;
  localparam logic [PINS-1:0] PIN_RST = 4'b1100; // hold_n, csn high; si, sck low

  logic [PINS-1:0] pins_s;
  logic sck_s, si_s, csn_s, hold_n_s;
  logic held_d, held_q;
  sck_evt_t evt;

  spi_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hold_n_i, csn_i, si_i, sck_i}),
    .q   (pins_s)
  );

  assign {hold_n_s, csn_s, si_s, sck_s} = pins_s;

  spi_hold_ctrl u_hold (
    .clk      (clk),
    .rst      (rst),
    .csn_s    (csn_s),
    .sck_s    (sck_s),
    .hold_n_s (hold_n_s),
    .held_d   (held_d),
    .held_q   (held_q)
  );

  spi_edge_gen u_edge (
    .clk    (clk),
    .rst    (rst),
    .sck_s  (sck_s),
    .csn_s  (csn_s),
    .held_q (held_q),
    .evt    (evt)
  );

  spi_bit_engine #(.DATA_W(DATA_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .held_d     (held_d),
    .held_q     (held_q),
    .si_s       (si_s),
    .tx_data_i  (tx_data_i),
    .tx_en_i    (tx_en_i),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );
endmodule

// File: tb/spi_hold_shifter_test.sv
module spi_hold_shifter_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, si = 1'b0, hold_n = 1'b1, tx_en = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic so, so_oe, rx_valid;
  logic [7:0] rx_data;

  int total = 0, bad = 0, rx_cnt = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_hold_shifter uut (
    .clk(clk), .rst(rst), .sck_i(sck), .csn_i(csn), .si_i(si), .hold_n_i(hold_n),
    .tx_data_i(tx_data), .tx_en_i(tx_en), .so_o(so), .so_oe_o(so_oe),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) if (!rst && rx_valid) begin
    rx_cnt++;
    last_rx = rx_data;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  // Clock idle low: one bit, sampled by master at the rise
  task automatic bit_lo(input logic b, output logic s);
    si = b; half(); sck = 1'b1; s = so; half(); sck = 1'b0;
  endtask

  task automatic byte_lo(input logic [7:0] mosi, input logic [7:0] nxt, output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      si = mosi[i]; half(); sck = 1'b1; miso[i] = so;
      if (i == 0) tx_data = nxt;
      half(); sck = 1'b0;
    end
    half();
  endtask

  // Clock idle high
  task automatic byte_hi(input logic [7:0] mosi, output logic [7:0] miso);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = mosi[i]; half(); sck = 1'b1; miso[i] = so; half();
    end
  endtask

  task automatic test_reset();
    check("R1 so_oe", so_oe, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 rx count", rx_cnt, 0);
  endtask

  task automatic test_mode_lo();
    logic [7:0] m0, m1;
    int c0 = rx_cnt;
    tx_data = 8'hC3; sck = 1'b0; csn = 1'b0; half();
    check("R5 oe in frame", so_oe, 1);
    byte_lo(8'hA5, 8'h5A, m0);
    check("R2 byte0", last_rx, 8'hA5);
    check("R3 miso0", m0, 8'hC3);
    byte_lo(8'h3C, 8'h00, m1);
    check("R2 byte1", last_rx, 8'h3C);
    check("R3 miso1 reload", m1, 8'h5A);
    check("R2 one strobe per byte", rx_cnt - c0, 2);
    csn = 1'b1; half();
    check("R5 oe cs high", so_oe, 0);
  endtask

  task automatic test_mode_hi();
    logic [7:0] m;
    sck = 1'b1; half(); tx_data = 8'h96; csn = 1'b0; half();
    byte_hi(8'h4E, m);
    check("R4 idle-high rx", last_rx, 8'h4E);
    check("R4 idle-high miso", m, 8'h96);
    csn = 1'b1; half(); sck = 1'b0; half();
  endtask

  task automatic test_tx_off();
    logic [7:0] m;
    tx_en = 1'b0; tx_data = 8'h11; csn = 1'b0; half();
    check("R5 oe tx_en low", so_oe, 0);
    byte_lo(8'h77, 8'h11, m);
    check("R5 rx still works", last_rx, 8'h77);
    csn = 1'b1; tx_en = 1'b1; half();
  endtask

  task automatic test_hold_basic();
    logic [7:0] m;
    logic s;
    int c0 = rx_cnt;
    tx_data = 8'hE1; csn = 1'b0; half();
    for (int i = 7; i >= 4; i--) begin bit_lo(8'hB6 >> i, s); m[i] = s; end
    half(); hold_n = 1'b0; half();
    check("R6 oe in hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = k[0]; half(); sck = 1'b1; half(); sck = 1'b0;
    end
    check("R7 no byte in hold", rx_cnt - c0, 0);
    hold_n = 1'b1; half();
    check("R6 oe after release", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin bit_lo(8'hB6 >> i, s); m[i] = s; end
    half();
    check("R7 rx across hold", last_rx, 8'hB6);
    check("R7 miso across hold", m, 8'hE1);
    csn = 1'b1; half();
  endtask

  // Hold changed while the clock is high; release coincides with a fall
  task automatic test_hold_deferred();
    logic [7:0] m;
    logic s;
    tx_data = 8'h3A; csn = 1'b0; half();
    for (int i = 7; i >= 5; i--) begin bit_lo(8'h6D >> i, s); m[i] = s; end
    si = 8'h6D >> 4; half(); sck = 1'b1; m[4] = so;
    hold_n = 1'b0; half();
    check("R8 entry deferred", so_oe, 1);
    sck = 1'b0; half();
    check("R6 held after clock low", so_oe, 0);
    sck = 1'b1; si = ~si; half();
    hold_n = 1'b1; half();
    check("R8 exit deferred", so_oe, 0);
    sck = 1'b0; half();
    check("R8 released at clock low", so_oe, 1);
    for (int i = 3; i >= 0; i--) begin bit_lo(8'h6D >> i, s); m[i] = s; end
    half();
    check("R10 rx release on fall", last_rx, 8'h6D);
    check("R10 miso release on fall", m, 8'h3A);
    csn = 1'b1; half();
  endtask

  // Hold entry coincides with a falling edge
  task automatic test_hold_on_fall();
    logic [7:0] m;
    logic s;
    tx_data = 8'hA6; csn = 1'b0; half();
    for (int i = 7; i >= 3; i--) begin bit_lo(8'h5B >> i, s); m[i] = s; end
    si = 8'h5B >> 2; half(); sck = 1'b1; m[2] = so; half();
    sck = 1'b0; hold_n = 1'b0; half();
    check("R10 held on fall", so_oe, 0);
    si = ~si; half(); hold_n = 1'b1; half();
    for (int i = 1; i >= 0; i--) begin bit_lo(8'h5B >> i, s); m[i] = s; end
    half();
    check("R10 rx entry on fall", last_rx, 8'h5B);
    check("R10 miso entry on fall", m, 8'hA6);
    csn = 1'b1; half();
  endtask

  task automatic test_abort();
    logic [7:0] m;
    logic s;
    int c0 = rx_cnt;
    tx_data = 8'hFF; csn = 1'b0; half();
    for (int i = 0; i < 3; i++) bit_lo(1'b1, s);
    half(); hold_n = 1'b0; half();
    sck = 1'b1; half();
    csn = 1'b1; half();
    hold_n = 1'b1; half();
    tx_data = 8'h24; csn = 1'b0; half();
    check("R9 hold cleared by cs", so_oe, 1);
    byte_hi(8'h81, m);
    check("R9 partial discarded", last_rx, 8'h81);
    check("R9 single byte", rx_cnt - c0, 1);
    check("R9 miso fresh frame", m, 8'h24);
    csn = 1'b1; half(); sck = 1'b0; half();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    test_reset();
    test_mode_lo();
    test_mode_hi();
    test_tx_off();
    test_hold_basic();
    test_hold_deferred();
    test_hold_on_fall();
    test_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule